// File: doc/BRIEF.md
# Receive Buffer with Per-Character and Accumulated Error Status

This block buffers received characters for one serial channel between the deserializer and the host. Each stored character carries three error flags: break seen, bad stop bit (framing) and bad parity. A queue of eight entries is fronted by a single holding slot. The holding slot absorbs one extra character while the queue is full. A further character that arrives while both are occupied is an overrun.

The host chooses how the error flags are presented. In per-character mode the flags follow the oldest byte, the one at the head of the queue. In accumulated mode the flags of every byte are ORed into sticky bits as the byte enters the queue. A bad byte is therefore reported before it reaches the head. A status-clear strobe resets the sticky bits and the overrun flag. A flow-control output lets the remote transmitter know when to stop sending. The host reads the head byte, the fill count, and ready and full indications.

Top module: `rx_fifo_stat`

## Requirements
- R1: The queue holds up to 8 entries. `head_data_o` shows the oldest entry, and entries leave in write order. `count_o` gives the number of entries in the queue, not counting the holding slot.
- R2: A pop while the queue is empty leaves `count_o` unchanged. A push while the queue is full, with no pop in the same cycle, leaves `count_o` unchanged.
- R3: A push while the queue is full, with no pop and the holding slot empty, stores the character in the holding slot. On the next effective pop the held character enters the queue tail in the same cycle, so `count_o` stays 8.
- R4: A push while the queue is full, with no pop and the holding slot occupied, sets `ovr_o`. It replaces the held character and leaves the queue contents intact. A push in the same cycle as a pop that moves the held character into the queue refills the holding slot and raises no overrun.
- R5: With `blk_mode_i`=0, `brk_o`, `fe_o` and `pe_o` are the flags stored with the head entry. All three are 0 when the queue is empty.
- R6: With `blk_mode_i`=1, the flag outputs are the OR of the flags of every character written into the queue since the last clear. This includes a character moved in from the holding slot. The OR is visible from the cycle after the write, whatever the head holds.
- R7: `stat_clr_i` clears the sticky flags and `ovr_o`. A flag set by a write or an overrun in the same cycle as the clear stays set.
- R8: `rdy_o` is 1 exactly when the queue is not empty. `full_o` is 1 exactly when it holds 8 entries.
- R9: `rts_o` is 0 while `rts_en_i`=1 and the queue is full. It is 1 otherwise.
- R10: After reset the queue and the holding slot are empty, all flags and `ovr_o` are 0, and `rts_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write strobe for one received character |
| push_data_i | input | 8 | Received byte |
| push_brk_i | input | 1 | Break flag of the received character |
| push_fe_i | input | 1 | Framing error flag of the received character |
| push_pe_i | input | 1 | Parity error flag of the received character |
| pop_i | input | 1 | Remove the head entry |
| blk_mode_i | input | 1 | 0 per-character status, 1 accumulated status |
| stat_clr_i | input | 1 | Clear the sticky flags and overrun |
| rts_en_i | input | 1 | Enable flow control on a full queue |
| head_data_o | output | 8 | Byte at the head of the queue |
| brk_o | output | 1 | Break status |
| fe_o | output | 1 | Framing error status |
| pe_o | output | 1 | Parity error status |
| ovr_o | output | 1 | Sticky overrun flag |
| rdy_o | output | 1 | Queue not empty |
| full_o | output | 1 | Queue holds 8 entries |
| count_o | output | 4 | Number of entries in the queue |
| rts_o | output | 1 | Remote may send (low to stop the sender) |

## Verification
The hardest case to reach is a pop on a full queue while the holding slot is occupied and a new character arrives in the same cycle. Three movements must then happen at once: the held byte enters the queue, the new byte takes the holding slot, and no overrun is raised. Directed sequences first fill the queue, load the holding slot and then hit this cycle with and without flags. Random traffic follows, biased towards pushes so that the queue stays near full and lands on it many more times. Mode switches and clears arrive while flagged bytes wait behind clean ones.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FLAG_W = 3;  // {brk, fe, pe}

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  rx_entry_t        wr_entry_i,
  input  logic             rd_i,
  output rx_entry_t        head_o,
  output logic [CNT_W-1:0] cnt_o
);
  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_i) rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(wr_i) - CNT_W'(rd_i);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (wr_i && wr_ptr_q == PTR_W'(i)) mem_q[i] <= wr_entry_i;
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import rx_fifo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      drain_i,
  input  rx_entry_t entry_i,
  output rx_entry_t entry_o,
  output logic      vld_o
);
  rx_entry_t ent_q;
  logic      vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (load_i) begin
        ent_q <= entry_i;
        vld_q <= 1'b1;
      end else if (drain_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign entry_o = ent_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/rx_stat_acc.sv
module rx_stat_acc
  import rx_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wr_flags_i,
  input  logic              ovr_set_i,
  output logic [FLAG_W-1:0] sticky_o,
  output logic              ovr_o
);
  logic [FLAG_W-1:0] sticky_q;
  logic              ovr_q;

  // set wins over a same-cycle clear
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sticky_q[i] <= 1'b0;
      else sticky_q[i] <= (sticky_q[i] & ~clr_i) | (wr_i & wr_flags_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else ovr_q <= (ovr_q & ~clr_i) | ovr_set_i;
  end

  assign sticky_o = sticky_q;
  assign ovr_o    = ovr_q;
endmodule

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_brk_i,
  input  logic              push_fe_i,
  input  logic              push_pe_i,
  input  logic              pop_i,
  input  logic              blk_mode_i,
  input  logic              stat_clr_i,
  input  logic              rts_en_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              brk_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              ovr_o,
  output logic              rdy_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              rts_o
);
  rx_entry_t         in_ent, head_ent, hold_ent, wr_ent;
  logic [CNT_W-1:0]  cnt;
  logic              empty, full, pop_eff, hold_vld, hold_in;
  logic              fifo_wr, hold_load, ovr_set;
  logic [FLAG_W-1:0] sticky, head_flags;

  assign in_ent  = '{flags: {push_brk_i, push_fe_i, push_pe_i}, data: push_data_i};
  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign pop_eff = pop_i & ~empty;
  assign hold_in = pop_eff & hold_vld;

  // held char has priority for the slot freed by a pop
  assign fifo_wr   = hold_in | (push_i & (~full | pop_eff));
  assign wr_ent    = hold_in ? hold_ent : in_ent;
  assign hold_load = push_i & ((full & ~pop_eff) | hold_in);
  assign ovr_set   = push_i & full & ~pop_eff & hold_vld;

  rx_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (fifo_wr),
    .wr_entry_i (wr_ent),
    .rd_i       (pop_eff),
    .head_o     (head_ent),
    .cnt_o      (cnt)
  );

  rx_hold_reg u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (hold_load),
    .drain_i (hold_in),
    .entry_i (in_ent),
    .entry_o (hold_ent),
    .vld_o   (hold_vld)
  );

  rx_stat_acc u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (stat_clr_i),
    .wr_i       (fifo_wr),
    .wr_flags_i (wr_ent.flags),
    .ovr_set_i  (ovr_set),
    .sticky_o   (sticky),
    .ovr_o      (ovr_o)
  );

  assign head_flags = empty ? '0 : head_ent.flags;

  always_comb begin
    if (blk_mode_i) {brk_o, fe_o, pe_o} = sticky;
    else            {brk_o, fe_o, pe_o} = head_flags;
  end

  assign head_data_o = head_ent.data;
  assign count_o     = cnt;
  assign rdy_o       = ~empty;
  assign full_o      = full;
  assign rts_o       = ~(rts_en_i & full);
endmodule

// File: rtl/rx_fifo_stat_chk.sv
module rx_fifo_stat_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             blk_mode_i,
  input logic             stat_clr_i,
  input logic             rts_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             rdy_o,
  input logic             ovr_o,
  input logic             brk_o,
  input logic             rts_o
);
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  a_r2_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && pop_i && !push_i) |=> !rdy_o);

  a_r2_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);

  a_r4_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(push_i && full_o && !pop_i));

  a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_mode_i && brk_o && !stat_clr_i) |=> (!blk_mode_i || brk_o));

  a_r7_ovr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !stat_clr_i) |=> ovr_o);

  a_r8_last_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_W'(1) && pop_i && !push_i) |=> !rdy_o);

  a_r9_rts_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_en_i && full_o) |-> !rts_o);
endmodule

bind rx_fifo_stat rx_fifo_stat_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .blk_mode_i (blk_mode_i),
  .stat_clr_i (stat_clr_i),
  .rts_en_i   (rts_en_i),
  .count_o    (count_o),
  .full_o     (full_o),
  .rdy_o      (rdy_o),
  .ovr_o      (ovr_o),
  .brk_o      (brk_o),
  .rts_o      (rts_o)
);

// File: tb/tb_rx_fifo_stat.sv
module tb_rx_fifo_stat;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       push_brk_i = 1'b0, push_fe_i = 1'b0, push_pe_i = 1'b0;
  logic       blk_mode_i = 1'b0, stat_clr_i = 1'b0, rts_en_i = 1'b0;
  logic [7:0] head_data_o;
  logic       brk_o, fe_o, pe_o, ovr_o, rdy_o, full_o, rts_o;
  logic [3:0] count_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [10:0] q[$];
  logic [10:0] m_hold = '0;
  bit          m_hv = 1'b0;
  logic [2:0]  m_stk = '0;
  bit          m_ovr = 1'b0;

  rx_fifo_stat dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [2:0] ef;
    if (blk_mode_i) ef = m_stk;
    else ef = (q.size() > 0) ? q[0][10:8] : 3'b000;
    check("R1 count", int'(count_o), q.size());
    if (q.size() > 0) check("R1 head", int'(head_data_o), int'(q[0][7:0]));
    check(blk_mode_i ? "R6 flags" : "R5 flags", int'({brk_o, fe_o, pe_o}), int'(ef));
    check("R4 ovr", int'(ovr_o), int'(m_ovr));
    check("R8 rdy", int'(rdy_o), int'(q.size() > 0));
    check("R8 full", int'(full_o), int'(q.size() == 8));
    check("R9 rts", int'(rts_o), int'(!(rts_en_i && q.size() == 8)));
  endtask

  // one cycle: drive at negedge, update model, check after the edge
  task automatic cyc(bit p, bit pp, logic [7:0] d, logic [2:0] f);
    bit full, pe_, hin;
    logic [10:0] e;
    @(negedge clk_i);
    push_i = p; pop_i = pp; push_data_i = d;
    {push_brk_i, push_fe_i, push_pe_i} = f;
    e = {f, d};
    full = (q.size() == 8);
    pe_ = pp && q.size() > 0;
    hin = pe_ && m_hv;
    if (stat_clr_i) begin m_stk = '0; m_ovr = 1'b0; end
    if (pe_) void'(q.pop_front());
    if (hin) begin q.push_back(m_hold); m_stk |= m_hold[10:8]; end
    if (p) begin
      if (hin) m_hold = e;
      else if (!full || pe_) begin q.push_back(e); m_stk |= f; end
      else begin
        if (m_hv) m_ovr = 1'b1;
        m_hold = e; m_hv = 1'b1;
      end
    end else if (hin) m_hv = 1'b0;
    @(posedge clk_i);
    #1;
    check_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    check("R10 count", int'(count_o), 0);
    check("R10 flags", int'({brk_o, fe_o, pe_o, ovr_o}), 0);
    check("R10 rts", int'(rts_o), 1);
    check("R10 rdy", int'(rdy_o), 0);

    // R2 pop on empty
    cyc(0, 1, 8'h00, 3'b000);
    check("R2 pop empty", int'(count_o), 0);

    // R1/R9 fill to full with rts enabled; entry 3 carries parity error
    rts_en_i = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1, 0, 8'(8'h10 + i), (i == 3) ? 3'b001 : 3'b000);
    check("R9 rts low on full", int'(rts_o), 0);
    // R3 ninth char to holding slot
    cyc(1, 0, 8'hA9, 3'b100);
    check("R2 push full count", int'(count_o), 8);
    check("R4 no ovr yet", int'(ovr_o), 0);
    // R4 tenth char overruns, overwrites holding
    cyc(1, 0, 8'hAA, 3'b010);
    check("R4 ovr set", int'(ovr_o), 1);
    check("R4 head kept", int'(head_data_o), 8'h10);
    // R4 pop with push: hold enters, new char held, no further effect
    cyc(1, 1, 8'hAB, 3'b000);
    check("R3 count stays 8", int'(count_o), 8);
    // R6 block mode: parity flag at entry 3 plus framing from held char
    blk_mode_i = 1'b1;
    cyc(0, 0, 8'h00, 3'b000);
    check("R6 block flags early", int'({brk_o, fe_o, pe_o}), 3'b011);
    // R7 clear
    stat_clr_i = 1'b1;
    cyc(0, 0, 8'h00, 3'b000);
    stat_clr_i = 1'b0;
    check("R7 cleared", int'({brk_o, fe_o, pe_o, ovr_o}), 0);
    // R7 clear with same-cycle set: pop moves held 0xAB(clean) in; push break too
    stat_clr_i = 1'b1;
    cyc(1, 1, 8'hAC, 3'b100);
    stat_clr_i = 1'b0;
    cyc(0, 0, 8'h00, 3'b000);
    // R5 char mode drains through flagged entries
    blk_mode_i = 1'b0;
    for (int i = 0; i < 12; i++) cyc(0, 1, 8'h00, 3'b000);
    check("R1 drained", int'(count_o), 0);
    check("R5 empty flags", int'({brk_o, fe_o, pe_o}), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit p, pp;
      logic [2:0] f;
      p  = ($urandom % 100) < 60;
      pp = ($urandom % 100) < 45;
      f  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      if (($urandom % 50) == 0) blk_mode_i = ~blk_mode_i;
      stat_clr_i = (($urandom % 40) == 0);
      if (($urandom % 30) == 0) rts_en_i = ~rts_en_i;
      cyc(p, pp, 8'($urandom), f);
    end
    stat_clr_i = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule